// File: doc/BRIEF.md
# Quadrature Rotary Encoder Position Decoder

This block turns the two phase outputs of a hand-turned rotary encoder into a small wrap-around position count. Phase A and phase B arrive as raw, asynchronous pins. Each pin is first brought into the clock domain through a flip-flop chain. The sampled pair is then kept as a newer and an older value. Any difference between the two is a step, and the block counts a step on every rising and falling edge of either phase. That gives four counts per full electrical cycle of the encoder.

The direction of each step is taken from the older sampled state and the new level of phase A. Contact bounce needs no timer. A bounce appears as an up step followed at once by a down step, and the two cancel in the count. A change of both phases between two samples cannot happen on a healthy encoder. When it does, the count is held and a one-cycle error strobe is raised. A synchronous reset loads the sample history from the live synchronised inputs, so the decoder starts in step with the encoder wherever the shaft is resting.

Top module: `quad_x4_decoder`

## Requirements
- R1: Each raw phase pin passes through two flip-flops before any decode logic uses it. A change at the pins reaches `count_o` on the fourth rising clock edge after it, and does not reach it on the third.
- R2: With the pair written {A,B}, the forward order is 00, 01, 11, 10, then back to 00. Each forward transition raises `count_o` by one, so one full cycle adds four.
- R3: Each transition of the reverse order (00, 10, 11, 01, then back to 00) lowers `count_o` by one.
- R4: While `rst_ni` is low, `count_o` is 4'b0101, `event_o` and `jump_err_o` are 0, `dir_up_o` is 1, and the sample history is cleared to 00.
- R5: While `sync_rst_i` is high, the newer and older history pairs are both loaded with the synchronised inputs. In that time the count does not change and no strobe is raised, so an encoder that rests away from 00 produces no step or error once the synchronous reset is released.
- R6: A bounce, meaning one phase toggling and then returning, leaves the net count unchanged. A bounce that finally settles on the new level leaves a net change of one.
- R7: When both phases change between consecutive samples, `count_o` is held and `jump_err_o` is high for exactly one cycle.
- R8: `count_o` wraps modulo 16 in both directions: 15 plus one gives 0, and 0 minus one gives 15.
- R9: `event_o` is high for exactly one cycle, in the cycle the count takes its new value. In that same cycle `dir_up_o` shows the direction of the step (1 = up) and keeps it until the next step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_rst_i | input | 1 | Synchronous reset, active high; loads the history from the inputs |
| phase_a_i | input | 1 | Raw encoder phase A |
| phase_b_i | input | 1 | Raw encoder phase B |
| count_o | output | 4 | Position count, modulo 16 |
| event_o | output | 1 | One-cycle strobe when the count steps |
| dir_up_o | output | 1 | Direction of the last step, 1 = up |
| jump_err_o | output | 1 | One-cycle strobe on a two-phase jump |

## Verification
The assertions assume the phase pins are quasi-static relative to the clock. Each level must be held long enough to cross the synchroniser and be sampled once. Under that assumption, every step the decoder sees differs from the previous sample in at most one phase, except where a jump is forced on purpose. The stimulus changes the pins only at the falling clock edge and holds each level for several cycles. It creates two-phase changes only in the scenario that checks the error strobe. Bounces are modelled as held levels that return, never as glitches shorter than a clock period.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  // sampled phase pair, bit 1 = A, bit 0 = B
  typedef logic [1:0] phase_t;

  // direction from older state and new A: B=0 -> new A high is down, B=1 -> new A high is up
  function automatic logic step_is_up(phase_t older, phase_t newer);
    return ~(older[0] ^ newer[1]);
  endfunction
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= raw_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/qdec_history.sv
module qdec_history
  import qdec_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  phase_t smp_i,
  output phase_t newer_o,
  output phase_t older_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      newer_o <= '0;
      older_o <= '0;
    end else if (load_i) begin
      newer_o <= smp_i;
      older_o <= smp_i;
    end else begin
      newer_o <= smp_i;
      older_o <= newer_o;
    end
  end

  p_preload_equal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (newer_o == older_o))
    else $error("history not equalised by preload");
endmodule

// File: rtl/qdec_step.sv
module qdec_step
  import qdec_pkg::*;
(
  input  phase_t newer_i,
  input  phase_t older_i,
  output logic   step_o,
  output logic   jump_o,
  output logic   up_o
);
  phase_t diff;

  always_comb begin
    diff   = newer_i ^ older_i;
    step_o = ^diff;
    jump_o = &diff;
    up_o   = step_is_up(older_i, newer_i);
  end
endmodule

// File: rtl/quad_x4_decoder.sv
module quad_x4_decoder
  import qdec_pkg::*;
#(
  parameter int          CNT_W      = 4,
  parameter int          SYNC_DEPTH = 2,
  parameter logic [CNT_W-1:0] CNT_INIT = 4'b0101
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_rst_i,
  input  logic             phase_a_i,
  input  logic             phase_b_i,
  output logic [CNT_W-1:0] count_o,
  output logic             event_o,
  output logic             dir_up_o,
  output logic             jump_err_o
);
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t ONE = cnt_t'(1);

  phase_t smp, newer, older;
  logic   step, jump, up;

  qdec_sync #(.WIDTH(2), .STAGES(SYNC_DEPTH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({phase_a_i, phase_b_i}),
    .sync_o (smp)
  );

  qdec_history u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sync_rst_i),
    .smp_i   (smp),
    .newer_o (newer),
    .older_o (older)
  );

  qdec_step u_step (
    .newer_i (newer),
    .older_i (older),
    .step_o  (step),
    .jump_o  (jump),
    .up_o    (up)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o    <= CNT_INIT;
      event_o    <= 1'b0;
      dir_up_o   <= 1'b1;
      jump_err_o <= 1'b0;
    end else begin
      event_o    <= step & ~sync_rst_i;
      jump_err_o <= jump & ~sync_rst_i;
      if (step && !sync_rst_i) begin
        count_o  <= up ? count_o + ONE : count_o - ONE;
        dir_up_o <= up;
      end
    end
  end

  p_step_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && dir_up_o) |-> (count_o == cnt_t'($past(count_o) + ONE)))
    else $error("up step not +1");

  p_step_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && !dir_up_o) |-> (count_o == cnt_t'($past(count_o) - ONE)))
    else $error("down step not -1");

  p_hold_no_event_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !event_o |-> $stable(count_o))
    else $error("count moved without event");

  p_jump_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({event_o, jump_err_o}))
    else $error("jump and step together");

  p_sync_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_rst_i |=> (!event_o && !jump_err_o))
    else $error("strobe during sync reset");
endmodule

// File: tb/sim_quad_x4_decoder.sv
`timescale 1ns/1ps
module sim_quad_x4_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       srst = 1'b0;
  logic       pa = 1'b0, pb = 1'b0;
  logic [3:0] count;
  logic       ev, dir_up, jerr;

  int checks = 0, fails = 0, cycles = 0;
  int ev_seen = 0, err_seen = 0;
  logic [1:0] ph = 2'b00;
  logic [3:0] model = 4'd5;

  always #2.5 clk = ~clk;

  quad_x4_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .sync_rst_i(srst),
    .phase_a_i(pa), .phase_b_i(pb),
    .count_o(count), .event_o(ev), .dir_up_o(dir_up), .jump_err_o(jerr)
  );

  always @(negedge clk) begin
    if (ev) ev_seen++;
    if (jerr) err_seen++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] fwd(input logic [1:0] s);
    case (s)
      2'b00: return 2'b01;
      2'b01: return 2'b11;
      2'b11: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  // drive new {A,B}, let it settle, update model
  task automatic move(input logic [1:0] nx);
    @(negedge clk);
    {pa, pb} = nx;
    if (nx == fwd(ph)) model = model + 4'd1;
    else if (ph == fwd(nx)) model = model - 4'd1;
    ph = nx;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R4 count", count, 5);
    chk("R4 event", ev, 0);
    chk("R4 dir", dir_up, 1);
    chk("R4 err", jerr, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 count after release", count, 5);
  endtask

  task automatic t_latency();
    int e0;
    @(negedge clk); pb = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 no change after 3 edges", count, 5);
    e0 = ev_seen;
    @(negedge clk);
    chk("R1 change after 4 edges", count, 6);
    chk("R9 event in update cycle", ev, 1);
    chk("R9 dir up", dir_up, 1);
    @(negedge clk);
    chk("R9 event one cycle", ev, 0);
    ph = 2'b01; model = 4'd6;
    repeat (3) @(negedge clk);
    chk("R9 single event", ev_seen - e0, 1);
  endtask

  task automatic t_forward();
    int e0 = ev_seen;
    logic [3:0] start = model;
    for (int i = 0; i < 4; i++) move(fwd(ph));
    chk("R2 full cycle +4", count, int'(start + 4'd4));
    chk("R2 four events", ev_seen - e0, 4);
    chk("R2 dir up", dir_up, 1);
  endtask

  task automatic t_reverse();
    logic [3:0] start = model;
    for (int i = 0; i < 4; i++) begin
      logic [1:0] prv = 2'b00;
      for (int k = 0; k < 4; k++) begin
        logic [1:0] s = k[1:0];
        if (fwd(s) == ph) prv = s;
      end
      move(prv);
    end
    chk("R3 full cycle -4", count, int'(start - 4'd4));
    chk("R3 dir down", dir_up, 0);
  endtask

  task automatic t_bounce();
    logic [1:0] org = ph, nx = fwd(ph);
    logic [3:0] start = model;
    move(nx); move(org); move(nx); move(org);
    chk("R6 bounce net zero", count, start);
    move(nx); move(org); move(nx);
    chk("R6 bounce settles +1", count, int'(start + 4'd1));
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 20; i++) move(fwd(ph));
    chk("R8 wrap up", count, model);
    chk("R8 wrap up value", count, 4'hF & (model));
    for (int i = 0; i < 22; i++) begin
      logic [1:0] prv = 2'b00;
      for (int k = 0; k < 4; k++) begin
        logic [1:0] s = k[1:0];
        if (fwd(s) == ph) prv = s;
      end
      move(prv);
    end
    chk("R8 wrap down", count, model);
  endtask

  task automatic t_jump();
    int e0 = err_seen, v0 = ev_seen;
    logic [3:0] start = model;
    move(~ph);
    chk("R7 count held", count, start);
    chk("R7 one error strobe", err_seen - e0, 1);
    chk("R7 no step event", ev_seen - v0, 0);
  endtask

  task automatic t_sync_reset();
    int e0, v0;
    @(negedge clk); rst_n = 1'b0; {pa, pb} = 2'b11; srst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 count reloaded", count, 5);
    e0 = err_seen; v0 = ev_seen;
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    srst = 1'b0;
    repeat (6) @(negedge clk);
    chk("R5 no error after preload", err_seen - e0, 0);
    chk("R5 no event after preload", ev_seen - v0, 0);
    chk("R5 count kept", count, 5);
    ph = 2'b11; model = 4'd5;
    move(fwd(ph));
    chk("R5 in step after preload", count, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_latency();
    t_forward();
    t_reverse();
    t_bounce();
    t_wrap();
    t_jump();
    t_sync_reset();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule